// File: doc/BRIEF.md
# Audio Master Clock Generator

This block turns a kernel clock into the three clocks one serial audio channel needs when it acts as the master. It produces a master clock for an external codec, a bit clock, and a frame sync at the sample rate. When the channel is a slave, the block stays idle and holds all three outputs low. Each channel in a chip has its own copy, and every copy behaves the same way.

A 4-bit divider code sets the master clock. A code of N greater than zero gives one master clock period for every 2N kernel cycles, with an exact 50% duty cycle. A code of zero sends the kernel clock straight through. A frame always spans 256 master clock periods. A frame length setting picks how many bit clocks fit in one frame, so the bit clock is a power-of-two division of the master clock. A flag can hold the master clock output low while the bit clock and the frame sync keep running.

The block captures its settings only while it is idle. It starts every run from a fixed phase, so the first period after the start is always full length. Apart from the two kernel clock bypass paths, every output comes from a register. The block uses no clock gating cells.

Top module: `aclk_gen`

## Requirements
- R1: While master_en is 0, mclk_o, bclk_o and fs_o are all 0. On the first kernel clock edge that sees master_en at 0, all three outputs drop to 0 and the internal counters return to zero.
- R2: For a captured divider code N from 1 to 15 with mclk_off at 0, mclk_o is low for N kernel cycles and then high for N kernel cycles. The first edge that sees master_en at 1 is the start edge. mclk_o first rises N edges after the start edge.
- R3: For a captured divider code of 0 with mclk_off at 0, mclk_o follows the kernel clock for as long as the generator runs.
- R4: With mclk_off captured as 1, mclk_o stays 0 during the whole run, and bclk_o and fs_o keep their normal waveforms.
- R5: The frame length is FL = 8 << fl_sel bit clocks, and fl_sel values 6 and 7 act like 5 (FL = 256). bclk_o has a period of 256/FL master clock periods, with a 50% duty cycle. It starts low at the start edge. When the divider code is 0 and FL is 256, bclk_o follows the kernel clock.
- R6: A frame is 256 master clock periods long. fs_o goes high at the start edge and stays high for the first 128 master clock periods of each frame, then stays low for the last 128. fs_o changes only on the same kernel edge as a falling edge of the bit clock.
- R7: div_code, fl_sel and mclk_off are captured on every edge that sees the generator idle, and the last capture is the start edge. A change to these inputs while the generator runs has no effect until the next start.
- R8: rst_n low forces all three outputs to 0 at once, without waiting for a clock edge. The block leaves reset synchronously, two kernel edges after rst_n rises.
- R9: If master_en falls part way through a frame and then rises again, the new run starts from the start phase with full-length first periods.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Kernel clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| master_en | input | 1 | 1 selects master mode (generator runs), 0 selects slave mode (idle) |
| div_code | input | 4 | Master clock divider code: 0 is bypass, N divides by 2N |
| mclk_off | input | 1 | 1 holds the master clock output at 0 |
| fl_sel | input | 3 | Frame length select, FL = 8 << fl_sel, saturating at 256 |
| mclk_o | output | 1 | Master clock to the external codec |
| bclk_o | output | 1 | Bit clock |
| fs_o | output | 1 | Frame sync, high for the first half of each frame |

## Verification
The assertions check these rules on every cycle:
- The outputs and the phase counter stay at zero while idle.
- The prescaler never reaches the divider code.
- The master clock does not change between prescaler ticks.
- The master clock stays low while the off flag is set.
- The captured settings stay fixed during a run.
- The frame sync changes only while the bit clock is low.

Some behaviour cannot be seen from one cycle, so the bench scenarios check it instead. This covers the exact period and phase of each clock, counted from the start edge, for several divider codes and frame lengths. The bench also checks the two kernel clock bypass paths by sampling them in both clock phases. Finally, it checks that settings changed mid-run are ignored, that a restart begins at full length, and that reset forces the outputs low before any clock edge.

// File: rtl/aclk_pkg.sv
package aclk_pkg;

  // Width of the master clock divider code.
  localparam int DIV_W = 4;
  // Width of the frame length select.
  localparam int FL_SEL_W = 3;
  // Largest meaningful frame length select (8 << 5 = 256 bit clocks).
  localparam int FL_SEL_MAX = 5;
  // Phase counter counts master clock half periods over one frame: 512.
  localparam int PHASE_W = FL_SEL_MAX + 4;
  // Stages of the reset release synchronizer.
  localparam int RST_STAGES = 2;

  typedef struct packed {
    logic [DIV_W-1:0]    div;
    logic [FL_SEL_W-1:0] fl;
    logic                mclk_off;
  } aclk_cfg_t;

endpackage

// File: rtl/aclk_rst_sync.sv
module aclk_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_s_n
);

  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
    end else begin
      sync_q <= sync_d;
    end
  end

  assign rst_s_n = sync_q[STAGES-1];

endmodule

// File: rtl/aclk_ctrl.sv
module aclk_ctrl
  import aclk_pkg::*;
#(
  parameter int P_DIV_W      = DIV_W,
  parameter int P_FL_SEL_W   = FL_SEL_W,
  parameter int P_FL_SEL_MAX = FL_SEL_MAX
) (
  input  logic                  clk,
  input  logic                  rst_s_n,
  input  logic                  master_en,
  input  logic [P_DIV_W-1:0]    div_code,
  input  logic [P_FL_SEL_W-1:0] fl_sel,
  input  logic                  mclk_off,
  output logic                  run_d,
  output logic                  run_q,
  output aclk_cfg_t             cfg_q
);

  localparam logic [P_FL_SEL_W-1:0] FL_TOP = P_FL_SEL_W'(P_FL_SEL_MAX);

  logic [P_FL_SEL_W-1:0] fl_sat;
  aclk_cfg_t             cfg_d;
  logic                  cfg_en;

  // Saturate frame length selects above the largest frame.
  always_comb begin
    fl_sat = (fl_sel > FL_TOP) ? FL_TOP : fl_sel;
  end

  // Run request and capture enable: settings load only while idle.
  always_comb begin
    run_d          = master_en;
    cfg_en         = !run_q;
    cfg_d.div      = div_code;
    cfg_d.fl       = fl_sat;
    cfg_d.mclk_off = mclk_off;
  end

  always_ff @(posedge clk or negedge rst_s_n) begin
    if (!rst_s_n) begin
      run_q <= 1'b0;
    end else begin
      run_q <= run_d;
    end
  end

  always_ff @(posedge clk or negedge rst_s_n) begin
    if (!rst_s_n) begin
      cfg_q <= '0;
    end else if (cfg_en) begin
      cfg_q <= cfg_d;
    end
  end

  AST_CFG_HOLD: assert property (@(posedge clk) disable iff (!rst_s_n)
    (run_q && $past(run_q)) |-> $stable(cfg_q)); // R7

endmodule

// File: rtl/aclk_prescale.sv
module aclk_prescale
  import aclk_pkg::*;
#(
  parameter int P_DIV_W = DIV_W
) (
  input  logic               clk,
  input  logic               rst_s_n,
  input  logic               run_q,
  input  logic [P_DIV_W-1:0] div,
  output logic               tick
);

  logic [P_DIV_W-1:0] pre_q;
  logic [P_DIV_W-1:0] pre_d;
  logic [P_DIV_W-1:0] pre_last;
  logic               bypass;

  always_comb begin
    bypass   = (div == '0);
    pre_last = div - P_DIV_W'(1);
    tick     = run_q && (bypass || (pre_q == pre_last));
  end

  always_comb begin
    if (!run_q || tick) begin
      pre_d = '0;
    end else begin
      pre_d = pre_q + P_DIV_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_s_n) begin
    if (!rst_s_n) begin
      pre_q <= '0;
    end else begin
      pre_q <= pre_d;
    end
  end

  AST_PRE_RANGE: assert property (@(posedge clk) disable iff (!rst_s_n)
    (run_q && (div != '0)) |-> (pre_q < div)); // R2

endmodule

// File: rtl/aclk_phase.sv
module aclk_phase
  import aclk_pkg::*;
#(
  parameter int P_PHASE_W    = PHASE_W,
  parameter int P_FL_SEL_W   = FL_SEL_W,
  parameter int P_FL_SEL_MAX = FL_SEL_MAX
) (
  input  logic      clk,
  input  logic      rst_s_n,
  input  logic      run_d,
  input  logic      run_q,
  input  logic      tick,
  input  aclk_cfg_t cfg,
  output logic      mclk_q,
  output logic      bclk_q,
  output logic      fs_q
);

  localparam int TAPS = 2 ** P_FL_SEL_W;

  logic [P_PHASE_W-1:0] ph_q;
  logic [P_PHASE_W-1:0] ph_d;
  logic [P_PHASE_W-1:0] step;
  logic [TAPS-1:0]      taps;
  logic                 mclk_d;
  logic                 bclk_d;
  logic                 fs_d;

  // In bypass one kernel cycle is a whole master clock period: step two halves.
  always_comb begin
    step = (cfg.div == '0) ? P_PHASE_W'(2) : P_PHASE_W'(1);
    if (!run_d) begin
      ph_d = '0;
    end else if (tick) begin
      ph_d = ph_q + step;
    end else begin
      ph_d = ph_q;
    end
  end

  // Bit clock tap: one phase bit per frame length.
  for (genvar g = 0; g < TAPS; g++) begin : g_tap
    if (g <= P_FL_SEL_MAX) begin : g_used
      assign taps[g] = ph_d[P_FL_SEL_MAX-g];
    end else begin : g_spare
      assign taps[g] = ph_d[0];
    end
  end

  always_comb begin
    mclk_d = run_d && ph_d[0] && !cfg.mclk_off;
    bclk_d = run_d && taps[cfg.fl];
    fs_d   = run_d && !ph_d[P_PHASE_W-1];
  end

  always_ff @(posedge clk or negedge rst_s_n) begin
    if (!rst_s_n) begin
      ph_q <= '0;
    end else begin
      ph_q <= ph_d;
    end
  end

  always_ff @(posedge clk or negedge rst_s_n) begin
    if (!rst_s_n) begin
      mclk_q <= 1'b0;
      bclk_q <= 1'b0;
      fs_q   <= 1'b0;
    end else begin
      mclk_q <= mclk_d;
      bclk_q <= bclk_d;
      fs_q   <= fs_d;
    end
  end

  AST_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rst_s_n)
    !run_q |-> ((ph_q == '0) && !mclk_q && !bclk_q && !fs_q)); // R1

  AST_MCLK_OFF: assert property (@(posedge clk) disable iff (!rst_s_n)
    (run_q && cfg.mclk_off) |-> !mclk_q); // R4

  AST_MCLK_HOLD: assert property (@(posedge clk) disable iff (!rst_s_n)
    (run_q && $past(run_q) && !$past(tick) && (cfg.div != '0)) |-> $stable(mclk_q)); // R2

  AST_FS_ON_BCLK_FALL: assert property (@(posedge clk) disable iff (!rst_s_n)
    (run_q && $past(run_q) && (fs_q != $past(fs_q))) |-> !bclk_q); // R6

endmodule

// File: rtl/aclk_gen.sv
module aclk_gen
  import aclk_pkg::*;
#(
  parameter int P_DIV_W      = DIV_W,
  parameter int P_FL_SEL_W   = FL_SEL_W,
  parameter int P_FL_SEL_MAX = FL_SEL_MAX,
  parameter int P_RST_STAGES = RST_STAGES
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  master_en,
  input  logic [P_DIV_W-1:0]    div_code,
  input  logic                  mclk_off,
  input  logic [P_FL_SEL_W-1:0] fl_sel,
  output logic                  mclk_o,
  output logic                  bclk_o,
  output logic                  fs_o
);

  localparam int P_PHASE_W = P_FL_SEL_MAX + 4;

  logic      rst_s_n;
  logic      run_d;
  logic      run_q;
  logic      tick;
  aclk_cfg_t cfg_q;
  logic      mclk_q;
  logic      bclk_q;
  logic      fs_q;
  logic      pass_mclk;
  logic      pass_bclk;

  aclk_rst_sync #(.STAGES(P_RST_STAGES)) u_rst_sync (
    .clk     (clk),
    .rst_n   (rst_n),
    .rst_s_n (rst_s_n)
  );

  aclk_ctrl #(
    .P_DIV_W      (P_DIV_W),
    .P_FL_SEL_W   (P_FL_SEL_W),
    .P_FL_SEL_MAX (P_FL_SEL_MAX)
  ) u_ctrl (
    .clk       (clk),
    .rst_s_n   (rst_s_n),
    .master_en (master_en),
    .div_code  (div_code),
    .fl_sel    (fl_sel),
    .mclk_off  (mclk_off),
    .run_d     (run_d),
    .run_q     (run_q),
    .cfg_q     (cfg_q)
  );

  aclk_prescale #(.P_DIV_W(P_DIV_W)) u_prescale (
    .clk     (clk),
    .rst_s_n (rst_s_n),
    .run_q   (run_q),
    .div     (cfg_q.div),
    .tick    (tick)
  );

  aclk_phase #(
    .P_PHASE_W    (P_PHASE_W),
    .P_FL_SEL_W   (P_FL_SEL_W),
    .P_FL_SEL_MAX (P_FL_SEL_MAX)
  ) u_phase (
    .clk     (clk),
    .rst_s_n (rst_s_n),
    .run_d   (run_d),
    .run_q   (run_q),
    .tick    (tick),
    .cfg     (cfg_q),
    .mclk_q  (mclk_q),
    .bclk_q  (bclk_q),
    .fs_q    (fs_q)
  );

  // Kernel clock pass-through paths, selected from registered state only.
  always_comb begin
    pass_mclk = run_q && (cfg_q.div == '0) && !cfg_q.mclk_off;
    pass_bclk = run_q && (cfg_q.div == '0) &&
                (cfg_q.fl == P_FL_SEL_W'(P_FL_SEL_MAX));
    mclk_o    = pass_mclk ? clk : mclk_q;
    bclk_o    = pass_bclk ? clk : bclk_q;
    fs_o      = fs_q;
  end

endmodule

// File: tb/aclk_gen_tb.sv
module aclk_gen_tb;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       master_en;
  logic [3:0] div_code;
  logic       mclk_off;
  logic [2:0] fl_sel;
  logic       mclk_o;
  logic       bclk_o;
  logic       fs_o;

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;
  bit done   = 0;

  localparam int WATCHDOG = 150000;
  // Vector fields: div[7:4], fl_sel[3:1], mclk_off[0].
  localparam logic [7:0] VECS [8] = '{8'h1A, 8'h30, 8'hF4, 8'h27,
                                      8'h06, 8'h0E, 8'h4C, 8'h03};

  always #4 clk = ~clk;

  aclk_gen u_dut (
    .clk       (clk),
    .rst_n     (rst_n),
    .master_en (master_en),
    .div_code  (div_code),
    .mclk_off  (mclk_off),
    .fl_sel    (fl_sel),
    .mclk_o    (mclk_o),
    .bclk_o    (bclk_o),
    .fs_o      (fs_o)
  );

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > WATCHDOG && !done) begin
      fails++;
      checks++;
      $display("FAIL watchdog: run hung, actual cycles %0d expected below %0d", cyc, WATCHDOG);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  // Expected {fs, bclk, mclk} k edges after the start edge; hi selects the clock phase.
  function automatic logic [2:0] model(int div, int fl, int off, int k, bit hi);
    int h, flc, kb;
    logic m, b, f;
    flc = (fl > 5) ? 5 : fl;
    kb  = 5 - flc;
    h   = (div == 0) ? ((2 * k) % 512) : ((k / div) % 512);
    if (div == 0) m = (off != 0) ? 1'b0 : hi;
    else          m = ((h % 2) == 1) && (off == 0);
    if (div == 0 && flc == 5) b = hi;
    else                      b = ((h >> kb) & 1) == 1;
    f = ((h >> 8) & 1) == 0;
    return {f, b, m};
  endfunction

  task automatic check_zero(input string tag);
    checks++;
    if ({fs_o, bclk_o, mclk_o} !== 3'b000) begin
      fails++;
      $display("FAIL %s: outputs {fs,bclk,mclk} actual %b expected 000", tag, {fs_o, bclk_o, mclk_o});
    end
  endtask

  task automatic run_window(input int div, input int fl, input int off, input int len,
                            input bit perturb, input string tag);
    int err [3];
    string tags [3];
    logic [2:0] act, exp;
    for (int s = 0; s < 3; s++) err[s] = 0;
    tags[0] = (off != 0) ? "R4" : ((div == 0) ? "R3" : "R2");
    tags[1] = "R5";
    tags[2] = "R6";
    if (tag != "") for (int s = 0; s < 3; s++) tags[s] = tag;
    @(negedge clk);
    div_code  = 4'(div);
    fl_sel    = 3'(fl);
    mclk_off  = off[0];
    master_en = 1'b1;
    @(posedge clk);
    for (int k = 0; k < len; k++) begin
      for (int p = 0; p < 2; p++) begin
        if (p == 0) #2; else #4;
        act = {fs_o, bclk_o, mclk_o};
        exp = model(div, fl, off, k, p == 0);
        for (int s = 0; s < 3; s++) begin
          if (act[s] !== exp[s]) begin
            if (err[s] == 0)
              $display("FAIL %s: div=%0d fl=%0d off=%0d signal %0d cycle %0d phase %0d actual %b expected %b",
                       tags[s], div, fl, off, s, k, p, act[s], exp[s]);
            err[s]++;
          end
        end
      end
      if (perturb && k == 10) begin
        div_code = 4'd7;
        fl_sel   = 3'd0;
        mclk_off = 1'b1;
      end
      @(posedge clk);
    end
    for (int s = 0; s < 3; s++) begin
      checks++;
      if (err[s] != 0) fails++;
    end
    @(negedge clk);
    master_en = 1'b0;
    @(posedge clk);
    #2;
    check_zero("R1 disable");
  endtask

  initial begin
    rst_n     = 1'b0;
    master_en = 1'b1;
    div_code  = 4'd1;
    fl_sel    = 3'd5;
    mclk_off  = 1'b0;
    #20;
    check_zero("R8 in reset");
    master_en = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(posedge clk);
    #2;
    check_zero("R1 idle after reset");

    // Table of settings, one full frame each.
    for (int v = 0; v < 8; v++) begin
      int d, f, o;
      d = int'(VECS[v][7:4]);
      f = int'(VECS[v][3:1]);
      o = int'(VECS[v][0]);
      run_window(d, f, o, (d == 0) ? 264 : (512 * d + 8), 1'b0, "");
    end

    // R7: settings changed mid-run are ignored.
    run_window(2, 5, 0, 1040, 1'b1, "R7");

    // R9: stop part way through a frame, then restart from the start phase.
    run_window(3, 2, 0, 100, 1'b0, "R9");
    run_window(3, 2, 0, 400, 1'b0, "R9");

    // R8: asynchronous reset during a run.
    @(negedge clk);
    div_code  = 4'd1;
    fl_sel    = 3'd5;
    mclk_off  = 1'b0;
    master_en = 1'b1;
    repeat (21) @(posedge clk);
    #2;
    rst_n = 1'b0;
    #1;
    check_zero("R8 async during run");
    master_en = 1'b0;
    #10;
    rst_n = 1'b1;
    repeat (4) @(posedge clk);
    #2;
    check_zero("R1 slave after reset");

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule